// File: doc/BRIEF.md
# Power-Domain Switch Sequencer

This block controls the power state of a set of power-gated domains (seven by default) from a small 32-bit register bus. Software first loads a mask of domains to switch on or a mask of domains to switch off. It then writes a short keyed byte sequence into a single command register. A parser checks each byte as it arrives. A complete, correct sequence starts a modelled power-switch delay of a parameterised number of cycles. When the delay ends, the requested domains change state in the power-mode register. Software can poll that register, or it can wait for the sequence-done interrupt.

Any byte that breaks the sequence, or any command written while a switch is still in progress, is refused. The refusal is reported as a software failure in a write-one-to-clear interrupt status register, which also has a mask. Domains marked as always-on can never be switched off. A request that changes no domain completes at once. Two stub inputs stand in for hardware requests and channel-failure reports, so that their status bits can be exercised.

Top module: `pds_ctrl`

## Requirements
- R1: After reset the power-mode register (offset 0x80) reads the always-on set (0x03 by default). The interrupt status (0x8C), the event status (0x88) and both request masks read 0. The interrupt mask (0x48) reads 0x1FF, and irq is low.
- R2: The turn-on mask (0x0C) and turn-off mask (0x10) hold one bit per domain, in bit i for domain i, and read back only the domain bits. A write to the read-only power-mode register has no effect.
- R3: Writing the bytes 0xFF, 0x05, 0x50 in that order to bits 7:0 of the command register (0x44) sets the turn-on-mask domains in the power-mode register. The change happens exactly SWITCH_CYCLES clock edges after the edge that accepts 0x50, and the register does not change at any other time.
- R4: Writing 0xFF, 0x0A, 0xA0 to the command register clears the turn-off-mask domains after the same delay.
- R5: Domains in the ALWAYS_ON set (bits 0 and 1 by default) always read 1, even when a turn-off request selects them.
- R6: A byte that does not continue the expected sequence returns the parser to idle and sets status bit 2. Only a new 0xFF restarts a sequence, so the two trailing bytes written without it switch nothing.
- R7: Any command write while a switch is in progress is rejected and sets status bit 3. The switch in progress still completes normally.
- R8: Completion sets status bit 0 on the cycle after the power-mode register changes. A request that changes no domain sets bit 0 one cycle after its last byte is accepted.
- R9: Writing ones to 0x8C clears exactly those status bits. Register 0x88 records, in bit i, each domain whose state changed, and it is cleared the same way.
- R10: A 1 in interrupt-mask bit k stops source k from being recorded in status bit k. irq is high whenever any status bit is set.
- R11: The stub input hw_req_in sets status bit 1. pch_fail_in[2:0] sets status bits 8:6. Status bits 5:4 have no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| hw_req_in | input | 1 | Stub hardware-request event |
| pch_fail_in | input | 3 | Stub channel-failure events |
| pwr_state | output | N_DOMAINS | Current power state, one bit per domain |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench builds the block with SWITCH_CYCLES set to 6 and keeps the default seven domains, with domains 0 and 1 always on. The short delay lets the bench find the exact edge on which the power mode changes. It also lets the bench land a command write inside the busy window and then follow the rejected switch through to completion. With the default domain count, the bench can show that always-on protection holds when an off mask selects those bits. It can also show that the upper data bits of a mask write are dropped.

// File: rtl/pds_pkg.sv
package pds_pkg;
   localparam int STAT_W = 9;

   localparam logic [7:0] OFS_ON_REQ  = 8'h0C;
   localparam logic [7:0] OFS_OFF_REQ = 8'h10;
   localparam logic [7:0] OFS_CMD     = 8'h44;
   localparam logic [7:0] OFS_IMASK   = 8'h48;
   localparam logic [7:0] OFS_MODE    = 8'h80;
   localparam logic [7:0] OFS_EVENT   = 8'h88;
   localparam logic [7:0] OFS_ISTAT   = 8'h8C;

   localparam logic [7:0] KEY_RESTART = 8'hFF;
   localparam logic [7:0] KEY_ON_LO   = 8'h05;
   localparam logic [7:0] KEY_ON_HI   = 8'h50;
   localparam logic [7:0] KEY_OFF_LO  = 8'h0A;
   localparam logic [7:0] KEY_OFF_HI  = 8'hA0;

   localparam int ST_DONE     = 0;
   localparam int ST_HWREQ    = 1;
   localparam int ST_SEQ_ERR  = 2;
   localparam int ST_BUSY_ERR = 3;
   localparam int ST_CH_LO    = 6;

   typedef enum logic [1:0] {
      PS_IDLE,
      PS_ARMED,
      PS_ON_LO,
      PS_OFF_LO
   } parse_state_e;
endpackage

// File: rtl/pds_cmd_parser.sv
module pds_cmd_parser
   import pds_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic [7:0] cmd_byte,
   input  logic       busy,
   output logic       fire_on,
   output logic       fire_off,
   output logic       fail_seq,
   output logic       fail_busy
);
   parse_state_e state_q, state_d;

   always_comb begin
      state_d   = state_q;
      fire_on   = 1'b0;
      fire_off  = 1'b0;
      fail_seq  = 1'b0;
      fail_busy = 1'b0;
      if (cmd_we) begin
         if (busy) begin
            fail_busy = 1'b1;
            state_d   = PS_IDLE;
         end else if (cmd_byte == KEY_RESTART) begin
            state_d = PS_ARMED;
         end else begin
            state_d = PS_IDLE;
            unique case (state_q)
               PS_ARMED: begin
                  if (cmd_byte == KEY_ON_LO)       state_d = PS_ON_LO;
                  else if (cmd_byte == KEY_OFF_LO) state_d = PS_OFF_LO;
                  else                             fail_seq = 1'b1;
               end
               PS_ON_LO: begin
                  if (cmd_byte == KEY_ON_HI) fire_on = 1'b1;
                  else                       fail_seq = 1'b1;
               end
               PS_OFF_LO: begin
                  if (cmd_byte == KEY_OFF_HI) fire_off = 1'b1;
                  else                        fail_seq = 1'b1;
               end
               default: fail_seq = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/pds_switch_unit.sv
module pds_switch_unit #(
   parameter int               N_DOMAINS     = 7,
   parameter logic [N_DOMAINS-1:0] ALWAYS_ON = 7'b0000011,
   parameter int               SWITCH_CYCLES = 500
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire_on,
   input  logic                 fire_off,
   input  logic [N_DOMAINS-1:0] on_req,
   input  logic [N_DOMAINS-1:0] off_req,
   output logic [N_DOMAINS-1:0] mode,
   output logic                 busy,
   output logic                 done,
   output logic [N_DOMAINS-1:0] changed
);
   localparam int CW = $clog2(SWITCH_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(SWITCH_CYCLES - 1);

   logic [CW-1:0]        cnt_q;
   logic [N_DOMAINS-1:0] pend_q;
   logic                 dir_on_q;
   logic [N_DOMAINS-1:0] eff;

   always_comb begin
      eff = '0;
      if (fire_on)       eff = on_req & ~mode;
      else if (fire_off) eff = off_req & mode & ~ALWAYS_ON;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= ALWAYS_ON;
         busy     <= 1'b0;
         done     <= 1'b0;
         changed  <= '0;
         cnt_q    <= '0;
         pend_q   <= '0;
         dir_on_q <= 1'b0;
      end else begin
         done    <= 1'b0;
         changed <= '0;
         if (fire_on || fire_off) begin
            if (eff == '0) begin
               done <= 1'b1;
            end else begin
               busy     <= 1'b1;
               cnt_q    <= CNT_LOAD;
               pend_q   <= eff;
               dir_on_q <= fire_on;
            end
         end else if (busy) begin
            if (cnt_q == '0) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               changed <= pend_q;
               mode    <= dir_on_q ? (mode | pend_q) : (mode & ~pend_q);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pds_status_regs.sv
module pds_status_regs
   import pds_pkg::*;
#(
   parameter int N_DOMAINS = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mask_we,
   input  logic                 stat_w1c,
   input  logic                 evt_w1c,
   input  logic [31:0]          wdata,
   input  logic [STAT_W-1:0]    sources,
   input  logic [N_DOMAINS-1:0] changed,
   output logic [STAT_W-1:0]    int_mask,
   output logic [STAT_W-1:0]    int_stat,
   output logic [N_DOMAINS-1:0] evt_stat
);
   logic [STAT_W-1:0]    stat_clr;
   logic [N_DOMAINS-1:0] evt_clr;

   assign stat_clr = stat_w1c ? wdata[STAT_W-1:0] : '0;
   assign evt_clr  = evt_w1c ? wdata[N_DOMAINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_mask <= '1;
         int_stat <= '0;
         evt_stat <= '0;
      end else begin
         if (mask_we) int_mask <= wdata[STAT_W-1:0];
         int_stat <= (int_stat & ~stat_clr) | (sources & ~int_mask);
         evt_stat <= (evt_stat & ~evt_clr) | changed;
      end
   end
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
   import pds_pkg::*;
#(
   parameter int                   N_DOMAINS     = 7,
   parameter logic [N_DOMAINS-1:0] ALWAYS_ON     = 7'b0000011,
   parameter int                   SWITCH_CYCLES = 500,
   parameter int                   CLK_NS        = 10,
   parameter int                   ADDR_W        = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 hw_req_in,
   input  logic [2:0]           pch_fail_in,
   output logic [N_DOMAINS-1:0] pwr_state,
   output logic                 irq
);
   localparam int MAX_SWITCH_NS = 100_000;

   generate
      if (N_DOMAINS < 1 || N_DOMAINS > 32) begin : g_bad_domains
         $error("N_DOMAINS must lie in 1..32");
      end
      if (SWITCH_CYCLES < 1 || SWITCH_CYCLES * CLK_NS > MAX_SWITCH_NS) begin : g_bad_delay
         $error("switch delay must be at least one cycle and at most 100 us");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must cover offsets up to 0x8C");
      end
   endgenerate

   logic [N_DOMAINS-1:0] on_req_q, off_req_q;
   logic                 fire_on, fire_off, fail_seq, fail_busy;
   logic                 sw_busy, sw_done;
   logic [N_DOMAINS-1:0] sw_changed;
   logic [STAT_W-1:0]    sources, int_mask, int_stat;
   logic [N_DOMAINS-1:0] evt_stat;
   logic                 wdata_unused;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign wdata_unused = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_req_q  <= '0;
         off_req_q <= '0;
      end else if (reg_we) begin
         if (hit(reg_addr, OFS_ON_REQ))  on_req_q  <= reg_wdata[N_DOMAINS-1:0];
         if (hit(reg_addr, OFS_OFF_REQ)) off_req_q <= reg_wdata[N_DOMAINS-1:0];
      end
   end

   pds_cmd_parser u_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (reg_we && hit(reg_addr, OFS_CMD)),
      .cmd_byte  (reg_wdata[7:0]),
      .busy      (sw_busy),
      .fire_on   (fire_on),
      .fire_off  (fire_off),
      .fail_seq  (fail_seq),
      .fail_busy (fail_busy)
   );

   pds_switch_unit #(
      .N_DOMAINS     (N_DOMAINS),
      .ALWAYS_ON     (ALWAYS_ON),
      .SWITCH_CYCLES (SWITCH_CYCLES)
   ) u_switch (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_on  (fire_on),
      .fire_off (fire_off),
      .on_req   (on_req_q),
      .off_req  (off_req_q),
      .mode     (pwr_state),
      .busy     (sw_busy),
      .done     (sw_done),
      .changed  (sw_changed)
   );

   always_comb begin
      sources                      = '0;
      sources[ST_DONE]             = sw_done;
      sources[ST_HWREQ]            = hw_req_in;
      sources[ST_SEQ_ERR]          = fail_seq;
      sources[ST_BUSY_ERR]         = fail_busy;
      sources[ST_CH_LO +: 3]       = pch_fail_in;
   end

   pds_status_regs #(.N_DOMAINS(N_DOMAINS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_we  (reg_we && hit(reg_addr, OFS_IMASK)),
      .stat_w1c (reg_we && hit(reg_addr, OFS_ISTAT)),
      .evt_w1c  (reg_we && hit(reg_addr, OFS_EVENT)),
      .wdata    (reg_wdata),
      .sources  (sources),
      .changed  (sw_changed),
      .int_mask (int_mask),
      .int_stat (int_stat),
      .evt_stat (evt_stat)
   );

   assign irq = |int_stat;

   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, OFS_ON_REQ))       reg_rdata[N_DOMAINS-1:0] = on_req_q;
      else if (hit(reg_addr, OFS_OFF_REQ)) reg_rdata[N_DOMAINS-1:0] = off_req_q;
      else if (hit(reg_addr, OFS_IMASK))   reg_rdata[STAT_W-1:0]    = int_mask;
      else if (hit(reg_addr, OFS_MODE))    reg_rdata[N_DOMAINS-1:0] = pwr_state;
      else if (hit(reg_addr, OFS_EVENT))   reg_rdata[N_DOMAINS-1:0] = evt_stat;
      else if (hit(reg_addr, OFS_ISTAT))   reg_rdata[STAT_W-1:0]    = int_stat;
   end
endmodule

// File: rtl/pds_ctrl_chk.sv
module pds_ctrl_chk
   import pds_pkg::*;
#(
   parameter int                   N_DOMAINS = 7,
   parameter logic [N_DOMAINS-1:0] ALWAYS_ON = 7'b0000011
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_DOMAINS-1:0] mode,
   input logic                 busy,
   input logic                 cmd_we,
   input logic                 fail_busy,
   input logic                 done,
   input logic                 stat_w1c,
   input logic [31:0]          wdata,
   input logic [STAT_W-1:0]    int_mask,
   input logic [STAT_W-1:0]    int_stat
);
   a_r5_always_on_held: assert property (@(posedge clk) disable iff (!rst_n)
      &(mode | ~ALWAYS_ON));

   a_r3_mode_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |-> $fell(busy));

   a_r7_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && busy) |-> fail_busy);

   a_r8_done_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !int_mask[ST_DONE]) |=> int_stat[ST_DONE]);

   a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_w1c && wdata[ST_DONE] && !done) |=> !int_stat[ST_DONE]);
endmodule

bind pds_ctrl pds_ctrl_chk #(
   .N_DOMAINS (N_DOMAINS),
   .ALWAYS_ON (ALWAYS_ON)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (pwr_state),
   .busy      (sw_busy),
   .cmd_we    (reg_we && (reg_addr == ADDR_W'(pds_pkg::OFS_CMD))),
   .fail_busy (fail_busy),
   .done      (sw_done),
   .stat_w1c  (reg_we && (reg_addr == ADDR_W'(pds_pkg::OFS_ISTAT))),
   .wdata     (reg_wdata),
   .int_mask  (int_mask),
   .int_stat  (int_stat)
);

// File: tb/pds_ctrl_test.sv
module pds_ctrl_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 6;
   localparam int ND = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          hw_req_in = 1'b0;
   logic [2:0]    pch_fail_in = '0;
   logic [ND-1:0] pwr_state;
   logic          irq;

   int  checks = 0;
   int  failures = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pds_ctrl #(.SWITCH_CYCLES(SW), .CLK_NS(CLK_PERIOD)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req_in(hw_req_in),
      .pch_fail_in(pch_fail_in), .pwr_state(pwr_state), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.2;
      d = reg_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmd_on();
      wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h50);
   endtask

   task automatic cmd_off();
      wr(8'h44, 32'hFF); wr(8'h44, 32'h0A); wr(8'h44, 32'hA0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      peek(8'h80, d); chk("R1 mode", d, 32'h03);
      peek(8'h8C, d); chk("R1 istat", d, 32'h0);
      peek(8'h48, d); chk("R1 imask", d, 32'h1FF);
      chk("R1 irq", {31'd0, irq}, 32'h0);
      wait_cyc(1);
      peek(8'h88, d); chk("R1 event", d, 32'h0);
      peek(8'h0C, d); chk("R1 on mask", d, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(8'h0C, 32'hFFFF_FFFC);
      peek(8'h0C, d); chk("R2 on mask readback", d, 32'h7C);
      wr(8'h10, 32'h0000_0013);
      peek(8'h10, d); chk("R2 off mask readback", d, 32'h13);
      wr(8'h80, 32'h0);
      peek(8'h80, d); chk("R2 mode write ignored", d, 32'h03);
   endtask

   task automatic t_power_on();
      logic [31:0] d;
      wr(8'h48, 32'h0);
      wr(8'h0C, 32'h14);
      cmd_on();
      wait_cyc(SW - 1);
      peek(8'h80, d); chk("R3 mode before delay", d, 32'h03);
      wait_cyc(1);
      peek(8'h80, d); chk("R3 mode after delay", d, 32'h17);
      wait_cyc(1);
      peek(8'h8C, d); chk("R8 done after switch", d, 32'h1);
      chk("R10 irq on done", {31'd0, irq}, 32'h1);
      peek(8'h88, d); chk("R9 event domains", d, 32'h14);
      wr(8'h8C, 32'h1);
      peek(8'h8C, d); chk("R9 istat cleared", d, 32'h0);
      chk("R10 irq cleared", {31'd0, irq}, 32'h0);
      wr(8'h88, 32'h04);
      peek(8'h88, d); chk("R9 event partial clear", d, 32'h10);
      wr(8'h88, 32'h7F);
   endtask

   task automatic t_power_off();
      logic [31:0] d;
      wr(8'h10, 32'h13);
      cmd_off();
      wait_cyc(SW + 1);
      peek(8'h80, d); chk("R4 R5 mode after off", d, 32'h07);
      peek(8'h88, d); chk("R4 event off", d, 32'h10);
      wr(8'h88, 32'h7F);
      wr(8'h8C, 32'h1FF);
   endtask

   task automatic t_bad_seq();
      logic [31:0] d;
      wr(8'h0C, 32'h08);
      wr(8'h44, 32'hFF); wr(8'h44, 32'h06);
      peek(8'h8C, d); chk("R6 seq error bit", d, 32'h4);
      wr(8'h44, 32'h05); wr(8'h44, 32'h50);
      wait_cyc(SW + 2);
      peek(8'h80, d); chk("R6 no switch without restart", d, 32'h07);
      peek(8'h8C, d); chk("R6 no done", d, 32'h4);
      wr(8'h8C, 32'h1FF);
   endtask

   task automatic t_busy();
      logic [31:0] d;
      wr(8'h0C, 32'h20);
      cmd_on();
      wr(8'h44, 32'hFF);
      peek(8'h8C, d); chk("R7 busy rejection bit", d, 32'h8);
      wait_cyc(SW + 1);
      peek(8'h80, d); chk("R7 switch completes", d, 32'h27);
      peek(8'h8C, d); chk("R7 R8 status after", d, 32'h9);
      wr(8'h8C, 32'h1FF);
      wr(8'h88, 32'h7F);
   endtask

   task automatic t_noop();
      logic [31:0] d;
      cmd_on();
      peek(8'h8C, d); chk("R8 noop not yet", d, 32'h0);
      wait_cyc(1);
      peek(8'h8C, d); chk("R8 noop done", d, 32'h1);
      peek(8'h80, d); chk("R8 noop mode", d, 32'h27);
      wr(8'h8C, 32'h1);
   endtask

   task automatic t_mask_stubs();
      logic [31:0] d;
      wr(8'h48, 32'h001);
      cmd_on();
      wait_cyc(3);
      peek(8'h8C, d); chk("R10 masked done", d, 32'h0);
      chk("R10 irq masked", {31'd0, irq}, 32'h0);
      hw_req_in = 1'b1;
      wait_cyc(1);
      hw_req_in = 1'b0;
      peek(8'h8C, d); chk("R11 hw request bit", d, 32'h2);
      chk("R10 irq from hw req", {31'd0, irq}, 32'h1);
      pch_fail_in = 3'b101;
      wait_cyc(1);
      pch_fail_in = 3'b000;
      peek(8'h8C, d); chk("R11 channel fail bits", d, 32'h142);
      wr(8'h8C, 32'h1FF);
      wr(8'h48, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_power_on();
      t_power_off();
      t_bad_seq();
      t_busy();
      t_noop();
      t_mask_stubs();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule